// File: doc/BRIEF.md
# Relative Clock Frequency Comparator

This block decides which of two unrelated clocks runs faster. Clock A is the reference domain. It marks out a measurement window of a fixed number of its own cycles. Clock B drives a free-running Gray-coded counter. That counter passes into the A domain through a two-flop synchronizer. At the end of each window the block compares how far the B count advanced against the window length. It then publishes a verdict with a one-cycle valid strobe.

The verdict has two bits. One says that A is faster. The other says that the two rates agree within a tolerance band. A new window starts as soon as the previous one ends, for as long as the enable input stays high. The first window after reset or after enable rises only primes the snapshot logic, so it yields no verdict. Typical use is a sanity check on clock sources, or choosing the faster of two clocks during bring-up.

Top module: `clkcmp_top`

## Requirements
- R1: While reset (rst_n low, asynchronous) is asserted and after its release, valid, a_faster and near_equal are all 0 until the first verdict.
- R2: Each measurement window lasts WIN cycles of clk_a. valid is high for exactly one clk_a cycle at the end of a window, and successive valid pulses are exactly WIN cycles apart.
- R3: The first window after enable rises produces no valid. Enable is sampled high at some clk_a edge; counting that edge as cycle 1, the first valid is visible after edge 2*WIN.
- R4: While en is low, no valid is produced and the window restarts. After en returns high, R3 applies again.
- R5: When the B count over a window is below WIN-TOL, the verdict is a_faster=1, near_equal=0.
- R6: When the B count over a window is above WIN+TOL, the verdict is a_faster=0, near_equal=0.
- R7: When the B count differs from WIN by at most TOL, near_equal=1 and a_faster=0. near_equal and a_faster are never both 1.
- R8: a_faster and near_equal change only together with a valid pulse and hold their value between pulses.
- R9: The B-domain counter value crossing to the A domain changes by at most one bit per clk_b edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Reference clock; sets the window and owns all outputs |
| clk_b | input | 1 | Clock under comparison |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| en | input | 1 | Run enable, clk_a domain; low halts and re-primes measurement |
| valid | output | 1 | One-cycle strobe marking a fresh verdict |
| a_faster | output | 1 | 1 when clk_a is faster than clk_b beyond the tolerance |
| near_equal | output | 1 | 1 when the two rates agree within TOL counts |

## Verification
The assertions assume that rst_n is released while both clocks run and that en changes only in step with clk_a. They also assume that clk_b stays below 2^CNT_W/WIN times the rate of clk_a, so the B counter cannot wrap within one window. The stimulus draws clk_b periods at random from a range that keeps this ratio at 8 or below. It discards any period whose ideal count lies within three counts of a tolerance edge, because synchronizer lag may shift a measurement by a count or two. All enable changes are driven on the falling edge of clk_a.

// File: rtl/clkcmp_pkg.sv
package clkcmp_pkg;

  typedef struct packed {
    logic faster;
    logic equal;
  } verdict_t;

  // Classify two edge counts taken over the same window.
  function automatic verdict_t classify(input int unsigned na,
                                        input int unsigned nb,
                                        input int unsigned tol);
    verdict_t    v;
    int unsigned gap;
    gap      = (na > nb) ? (na - nb) : (nb - na);
    v.equal  = (gap <= tol);
    v.faster = !v.equal && (na > nb);
    return v;
  endfunction

endpackage

// File: rtl/clkcmp_gray_cnt.sv
module clkcmp_gray_cnt #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] gray_o
);

  function automatic logic [W-1:0] to_gray(input logic [W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic [W-1:0] bin_q;
  logic [W-1:0] bin_nx;

  assign bin_nx = bin_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_o <= '0;
    end else begin
      bin_q  <= bin_nx;
      gray_o <= to_gray(bin_nx);
    end
  end

  assert_gray_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gray_o ^ $past(gray_o)) <= 1);

endmodule

// File: rtl/clkcmp_sync.sv
module clkcmp_sync #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end

endmodule

// File: rtl/clkcmp_window.sv
module clkcmp_window #(
  parameter int unsigned WIN = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic win_end_o,
  output logic primed_o
);

  localparam int unsigned WIN_W = (WIN > 1) ? $clog2(WIN) : 1;

  logic [WIN_W-1:0] cnt_q;

  assign win_end_o = en && (cnt_q == WIN_W'(WIN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      primed_o <= 1'b0;
    end else if (!en) begin
      cnt_q    <= '0;
      primed_o <= 1'b0;
    end else if (win_end_o) begin
      cnt_q    <= '0;
      primed_o <= 1'b1;
    end else begin
      cnt_q    <= cnt_q + 1'b1;
    end
  end

  assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= WIN_W'(WIN - 1));

  assert_idle_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0) && !primed_o);

endmodule

// File: rtl/clkcmp_top.sv
module clkcmp_top #(
  parameter int unsigned WIN   = 64,
  parameter int unsigned CNT_W = 10,
  parameter int unsigned TOL   = 4
) (
  input  logic clk_a,
  input  logic clk_b,
  input  logic rst_n,
  input  logic en,
  output logic valid,
  output logic a_faster,
  output logic near_equal
);
  import clkcmp_pkg::*;

  function automatic logic [CNT_W-1:0] from_gray(input logic [CNT_W-1:0] g);
    logic [CNT_W-1:0] b;
    b[CNT_W-1] = g[CNT_W-1];
    for (int i = int'(CNT_W) - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [CNT_W-1:0] gray_b;
  logic [CNT_W-1:0] gray_a;
  logic [CNT_W-1:0] b_now;
  logic [CNT_W-1:0] b_prev_q;
  logic [CNT_W-1:0] b_delta;
  logic             win_end;
  logic             primed;
  verdict_t         verdict;

  clkcmp_gray_cnt #(.W(CNT_W)) u_bcnt (
    .clk(clk_b), .rst_n(rst_n), .gray_o(gray_b)
  );

  clkcmp_sync #(.W(CNT_W)) u_sync (
    .clk(clk_a), .rst_n(rst_n), .d(gray_b), .q(gray_a)
  );

  clkcmp_window #(.WIN(WIN)) u_win (
    .clk(clk_a), .rst_n(rst_n), .en(en),
    .win_end_o(win_end), .primed_o(primed)
  );

  assign b_now   = from_gray(gray_a);
  assign b_delta = b_now - b_prev_q;
  assign verdict = classify(WIN, {{(32-CNT_W){1'b0}}, b_delta}, TOL);

  always_ff @(posedge clk_a or negedge rst_n) begin
    if (!rst_n) begin
      b_prev_q   <= '0;
      valid      <= 1'b0;
      a_faster   <= 1'b0;
      near_equal <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (win_end) begin
        b_prev_q <= b_now;
        if (primed) begin
          valid      <= 1'b1;
          a_faster   <= verdict.faster;
          near_equal <= verdict.equal;
        end
      end
    end
  end

  assert_single_pulse_R2: assert property (@(posedge clk_a) disable iff (!rst_n)
    valid |=> !valid);

  assert_no_prime_no_valid_R3: assert property (@(posedge clk_a) disable iff (!rst_n)
    valid |-> $past(primed));

  assert_disabled_quiet_R4: assert property (@(posedge clk_a) disable iff (!rst_n)
    !en |=> !valid);

  assert_exclusive_R7: assert property (@(posedge clk_a) disable iff (!rst_n)
    !(near_equal && a_faster));

  assert_hold_R8: assert property (@(posedge clk_a) disable iff (!rst_n)
    !valid |-> $stable({a_faster, near_equal}));

endmodule

// File: tb/clkcmp_top_tb.sv
`timescale 1ps/1ps
module clkcmp_top_tb;
  localparam int WIN   = 64;
  localparam int CNT_W = 10;
  localparam int TOL   = 4;
  localparam int TA_PS = 8000;

  logic clk_a = 1'b0;
  logic clk_b = 1'b0;
  logic rst_n = 1'b0;
  logic en    = 1'b0;
  logic valid, a_faster, near_equal;
  int   half_b = 4000;
  int   n_chk = 0;
  int   n_bad = 0;
  int   cyc = 0;

  clkcmp_top #(.WIN(WIN), .CNT_W(CNT_W), .TOL(TOL)) u_dut (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .en(en),
    .valid(valid), .a_faster(a_faster), .near_equal(near_equal)
  );

  always #(TA_PS/2) clk_a = ~clk_a;
  always begin #(half_b); clk_b = ~clk_b; end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk_a) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual cycle %0d expected under 150000", cyc);
      finish_run();
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected verdict from the ideal B count over one window.
  function automatic int exp_faster(input int tb_ps);
    real ideal = real'(WIN) * real'(TA_PS) / real'(tb_ps);
    return (ideal < real'(WIN - TOL)) ? 1 : 0;
  endfunction
  function automatic int exp_equal(input int tb_ps);
    real ideal = real'(WIN) * real'(TA_PS) / real'(tb_ps);
    real gap = (ideal > WIN) ? ideal - WIN : WIN - ideal;
    return (gap <= real'(TOL)) ? 1 : 0;
  endfunction
  function automatic bit safe_period(input int tb_ps);
    real ideal = real'(WIN) * real'(TA_PS) / real'(tb_ps);
    real gap = (ideal > WIN) ? ideal - WIN : WIN - ideal;
    return (gap <= real'(TOL - 3)) || (gap >= real'(TOL + 3));
  endfunction

  // Waits for the next valid; returns cycles waited (-1 on timeout).
  task automatic wait_valid(output int waited);
    waited = -1;
    for (int i = 1; i <= 4*WIN; i++) begin
      @(negedge clk_a);
      if (valid) begin waited = i; break; end
    end
  endtask

  task automatic measure(input int tb_ps, input string tag);
    int w;
    half_b = tb_ps / 2;
    wait_valid(w);
    wait_valid(w);
    check({tag, " valid seen"}, (w > 0) ? 1 : 0, 1);
    check({tag, " a_faster"}, int'(a_faster), exp_faster(tb_ps));
    check({tag, " near_equal"}, int'(near_equal), exp_equal(tb_ps));
  endtask

  initial begin
    int w, seen, per;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_a);
    check("R1 valid in reset", int'(valid), 0);
    check("R1 flags in reset", int'(a_faster | near_equal), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk_a);
    check("R1 valid after release", int'(valid), 0);

    // R3: first valid exactly 2*WIN edges after enable
    en = 1'b1;
    seen = 0;
    for (int i = 1; i <= 3*WIN; i++) begin
      @(negedge clk_a);
      if (valid && seen == 0) seen = i;
    end
    check("R3 first valid cycle", seen, 2*WIN);

    // R2: pulse width and spacing
    wait_valid(w);
    @(negedge clk_a);
    check("R2 pulse one cycle", int'(valid), 0);
    wait_valid(w);
    check("R2 spacing", w + 1, WIN);

    // R8: flags hold between pulses
    begin
      logic f0, e0; int moved = 0;
      f0 = a_faster; e0 = near_equal;
      half_b = 1000;
      for (int i = 0; i < WIN - 2; i++) begin
        @(negedge clk_a);
        if (!valid && (a_faster != f0 || near_equal != e0)) moved = 1;
      end
      check("R8 flags stable", moved, 0);
    end

    // R4: enable low produces nothing, then re-primes
    en = 1'b0;
    seen = 0;
    for (int i = 0; i < 3*WIN; i++) begin
      @(negedge clk_a);
      if (valid) seen++;
    end
    check("R4 no valid while disabled", seen, 0);
    en = 1'b1;
    seen = 0;
    for (int i = 1; i <= 3*WIN; i++) begin
      @(negedge clk_a);
      if (valid && seen == 0) seen = i;
    end
    check("R4 re-prime first valid", seen, 2*WIN);

    // Directed verdicts
    measure(16000, "R5 B half speed");
    measure(40000, "R5 B slow");
    measure(4000,  "R6 B double");
    measure(1000,  "R6 B eightfold");
    measure(8000,  "R7 identical");
    measure(7758,  "R7 within band");
    measure(9000,  "R5 just beyond band");

    // Random periods away from the band edges
    for (int k = 0; k < 20; k++) begin
      do per = 2 * (500 + int'($urandom_range(0, 19500))); while (!safe_period(per));
      if (exp_equal(per) == 1)       measure(per, "R7 random");
      else if (exp_faster(per) == 1) measure(per, "R5 random");
      else                           measure(per, "R6 random");
    end

    finish_run();
  end
endmodule